// File: doc/BRIEF.md
# DMA Channel Request and Error-Interrupt Enable Bank

This block is the per-channel enable store for a 16-channel DMA engine. It keeps two bitmaps. The request-enable map decides which channels may accept hardware DMA requests. The error-interrupt enable map decides which channels may turn an error into an interrupt request. Each map can be rewritten whole through a full-width write port. A single channel can also be set or cleared through dedicated set and clear ports that take a channel code, so software never needs a read-modify-write. A code with its broadcast bit set acts on every channel at once.

The bank also drives one registered error-interrupt request per channel. A request is raised only while that channel's error indicator and its enable are both 1. When a channel finishes its major loop and its descriptor carries the disable-request flag, the bank drops that channel's request enable by itself. A small read mux returns either map, and returns zero for the set and clear port addresses.

Top module: `dma_chan_enable_bank`

## Requirements
- R1: While `rst` is high and on the first cycle after it, both maps and all `err_irq` bits are 0.
- R2: A full write (`req_wr` or `err_wr`) replaces all 16 bits of that map with the write data at the next clock edge.
- R3: A set strobe with a code whose bit 6 is 0 sets the bit of the channel given by code bits 3..0 and leaves every other bit unchanged; code bits 7, 5 and 4 are ignored.
- R4: A clear strobe with a code whose bit 6 is 0 clears the bit of the channel given by code bits 3..0 and leaves every other bit unchanged.
- R5: A set or clear code with bit 6 at 1 applies to all 16 channels of that map.
- R6: In one cycle on one map, a full write is applied first, then a set, then a clear; the clear wins over a set to the same bit.
- R7: `err_irq[n]` is a register that holds `ch_err[n] AND err_map[n]` sampled on the previous clock edge; with the enable at 0 it stays 0 whatever `ch_err[n]` does.
- R8: When `major_done[n]` and `dreq_flag[n]` are both 1, `req_map[n]` is 0 after the edge; when `dreq_flag[n]` is 0, major-loop completion leaves `req_map[n]` unchanged.
- R9: The completion auto-clear of R8 wins over a full write or a set that targets the same request bit in the same cycle.
- R10: `rd_data` shows `req_map` for `rd_sel` 0, `err_map` for `rd_sel` 1, and 0 for every other select (2 to 5 being the set and clear ports); reading has no effect on either map.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_wr | input | 1 | Full write strobe for the request map |
| req_wdata | input | 16 | Full write data for the request map |
| req_set | input | 1 | Set strobe for the request map |
| req_set_code | input | 8 | Channel code for the request set |
| req_clr | input | 1 | Clear strobe for the request map |
| req_clr_code | input | 8 | Channel code for the request clear |
| err_wr | input | 1 | Full write strobe for the error-enable map |
| err_wdata | input | 16 | Full write data for the error-enable map |
| err_set | input | 1 | Set strobe for the error-enable map |
| err_set_code | input | 8 | Channel code for the error-enable set |
| err_clr | input | 1 | Clear strobe for the error-enable map |
| err_clr_code | input | 8 | Channel code for the error-enable clear |
| ch_err | input | 16 | Per-channel error indicators |
| major_done | input | 16 | Per-channel major-loop completion pulses |
| dreq_flag | input | 16 | Per-channel descriptor disable-request flags |
| rd_sel | input | 3 | Read select |
| rd_data | output | 16 | Read data |
| req_map | output | 16 | Current request-enable map |
| err_map | output | 16 | Current error-interrupt enable map |
| err_irq | output | 16 | Registered per-channel error-interrupt requests |

## Verification
The bench builds the bank with its default 16 channels, an 8-bit channel code and the broadcast flag at bit 6, so every channel index, the broadcast path and the ignored code bits 7, 5 and 4 can all be reached by random codes. With 16 channels, random completion and flag vectors regularly land on bits that a write or set is also touching in the same cycle, which exercises the R9 priority. Random set and clear pairs on a small index space often collide on one channel, which exercises the R6 ordering.

// File: rtl/dma_enable_pkg.sv
package dma_enable_pkg;
  localparam int unsigned CODE_W  = 8;
  localparam int unsigned MAX_CH  = 64;

  // Turn a set/clear channel code into a one-hot or all-ones mask.
  function automatic logic [MAX_CH-1:0] code_mask(
    input logic [CODE_W-1:0] code,
    input int unsigned       nch,
    input int unsigned       all_bit,
    input int unsigned       chw
  );
    logic [MAX_CH-1:0] m;
    logic [CODE_W-1:0] idx;
    if (code[all_bit]) begin
      m = (nch >= MAX_CH) ? '1 : ((MAX_CH'(1) << nch) - MAX_CH'(1));
    end else begin
      idx = code & CODE_W'((1 << chw) - 1);
      m   = MAX_CH'(1) << idx;
    end
    return m;
  endfunction
endpackage

// File: rtl/en_bitmap.sv
module en_bitmap
  import dma_enable_pkg::*;
#(
  parameter int unsigned NUM_CH  = 16,
  parameter int unsigned ALL_BIT = 6
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr,
  input  logic [NUM_CH-1:0] wdata,
  input  logic              set,
  input  logic [CODE_W-1:0] set_code,
  input  logic              clr,
  input  logic [CODE_W-1:0] clr_code,
  input  logic [NUM_CH-1:0] hw_clr,
  output logic [NUM_CH-1:0] set_mask,
  output logic [NUM_CH-1:0] clr_mask,
  output logic [NUM_CH-1:0] q
);
  localparam int unsigned CH_W = (NUM_CH > 1) ? $clog2(NUM_CH) : 1;

  logic [MAX_CH-1:0] set_full, clr_full;
  logic [NUM_CH-1:0] nxt;

  assign set_full = code_mask(set_code, NUM_CH, ALL_BIT, CH_W);
  assign clr_full = code_mask(clr_code, NUM_CH, ALL_BIT, CH_W);
  assign set_mask = set ? set_full[NUM_CH-1:0] : '0;
  assign clr_mask = clr ? clr_full[NUM_CH-1:0] : '0;

  // Order: full write, then set, then clear, then hardware clear.
  always_comb begin
    nxt = wr ? wdata : q;
    nxt = nxt | set_mask;
    nxt = nxt & ~clr_mask;
    nxt = nxt & ~hw_clr;
  end

  always_ff @(posedge clk) begin
    if (rst) q <= '0;
    else     q <= nxt;
  end
endmodule

// File: rtl/irq_gate.sv
module irq_gate #(
  parameter int unsigned NUM_CH = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [NUM_CH-1:0] err_in,
  input  logic [NUM_CH-1:0] en,
  output logic [NUM_CH-1:0] irq
);
  for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
    always_ff @(posedge clk) begin
      if (rst) irq[g] <= 1'b0;
      else     irq[g] <= err_in[g] & en[g];
    end
  end
endmodule

// File: rtl/dma_chan_enable_bank.sv
module dma_chan_enable_bank
  import dma_enable_pkg::*;
#(
  parameter int unsigned NUM_CH  = 16,
  parameter int unsigned ALL_BIT = 6
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_wr,
  input  logic [NUM_CH-1:0] req_wdata,
  input  logic              req_set,
  input  logic [CODE_W-1:0] req_set_code,
  input  logic              req_clr,
  input  logic [CODE_W-1:0] req_clr_code,
  input  logic              err_wr,
  input  logic [NUM_CH-1:0] err_wdata,
  input  logic              err_set,
  input  logic [CODE_W-1:0] err_set_code,
  input  logic              err_clr,
  input  logic [CODE_W-1:0] err_clr_code,
  input  logic [NUM_CH-1:0] ch_err,
  input  logic [NUM_CH-1:0] major_done,
  input  logic [NUM_CH-1:0] dreq_flag,
  input  logic [2:0]        rd_sel,
  output logic [NUM_CH-1:0] rd_data,
  output logic [NUM_CH-1:0] req_map,
  output logic [NUM_CH-1:0] err_map,
  output logic [NUM_CH-1:0] err_irq
);
  localparam logic [2:0] SEL_REQ = 3'd0;
  localparam logic [2:0] SEL_ERR = 3'd1;

  // Named internal events for the checker.
  logic [NUM_CH-1:0] auto_clr;
  logic [NUM_CH-1:0] req_set_mask, req_clr_mask;
  logic [NUM_CH-1:0] err_set_mask, err_clr_mask;

  assign auto_clr = major_done & dreq_flag;

  en_bitmap #(.NUM_CH(NUM_CH), .ALL_BIT(ALL_BIT)) u_req (
    .clk(clk), .rst(rst),
    .wr(req_wr), .wdata(req_wdata),
    .set(req_set), .set_code(req_set_code),
    .clr(req_clr), .clr_code(req_clr_code),
    .hw_clr(auto_clr),
    .set_mask(req_set_mask), .clr_mask(req_clr_mask),
    .q(req_map)
  );

  en_bitmap #(.NUM_CH(NUM_CH), .ALL_BIT(ALL_BIT)) u_err (
    .clk(clk), .rst(rst),
    .wr(err_wr), .wdata(err_wdata),
    .set(err_set), .set_code(err_set_code),
    .clr(err_clr), .clr_code(err_clr_code),
    .hw_clr({NUM_CH{1'b0}}),
    .set_mask(err_set_mask), .clr_mask(err_clr_mask),
    .q(err_map)
  );

  irq_gate #(.NUM_CH(NUM_CH)) u_irq (
    .clk(clk), .rst(rst),
    .err_in(ch_err), .en(err_map),
    .irq(err_irq)
  );

  always_comb begin
    unique case (rd_sel)
      SEL_REQ: rd_data = req_map;
      SEL_ERR: rd_data = err_map;
      default: rd_data = '0;
    endcase
  end
endmodule

// File: rtl/dma_chan_enable_bank_chk.sv
module dma_chan_enable_bank_chk #(
  parameter int unsigned NUM_CH = 16
) (
  input logic              clk,
  input logic              rst,
  input logic              req_wr,
  input logic              err_wr,
  input logic [NUM_CH-1:0] err_wdata,
  input logic              err_set,
  input logic              err_clr,
  input logic [NUM_CH-1:0] ch_err,
  input logic [NUM_CH-1:0] auto_clr,
  input logic [NUM_CH-1:0] req_set_mask,
  input logic [NUM_CH-1:0] err_set_mask,
  input logic [NUM_CH-1:0] err_clr_mask,
  input logic [2:0]        rd_sel,
  input logic [NUM_CH-1:0] rd_data,
  input logic [NUM_CH-1:0] req_map,
  input logic [NUM_CH-1:0] err_map,
  input logic [NUM_CH-1:0] err_irq
);
  logic rst_d;
  always_ff @(posedge clk) rst_d <= rst;

  // R1: state is cleared on the cycle after reset is seen.
  always_ff @(posedge clk) begin
    if (rst_d) begin
      a_r1_reset_clear: assert (req_map == '0 && err_map == '0 && err_irq == '0);
    end
  end

  a_r2_full_write: assert property (@(posedge clk) disable iff (rst)
    (err_wr && !err_set && !err_clr) |=> (err_map == $past(err_wdata)));

  a_r3_set_hits: assert property (@(posedge clk) disable iff (rst)
    (err_set && !err_clr) |=> ((err_map & $past(err_set_mask)) == $past(err_set_mask)));

  a_r6_clear_wins: assert property (@(posedge clk) disable iff (rst)
    err_clr |=> ((err_map & $past(err_clr_mask)) == '0));

  a_r7_irq_gated: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (err_irq == ($past(ch_err) & $past(err_map))));

  a_r9_autoclear_wins: assert property (@(posedge clk) disable iff (rst)
    ((auto_clr != '0) && (req_wr || req_set_mask != '0)) |=> ((req_map & $past(auto_clr)) == '0));

  a_r4_err_hold: assert property (@(posedge clk) disable iff (rst)
    (!err_wr && !err_set && !err_clr) |=> $stable(err_map));

  // R10: unused selects read as zero.
  always_comb begin
    if (!rst && rd_sel > 3'd1) begin
      a_r10_read_zero: assert (rd_data == '0);
    end
  end
endmodule

bind dma_chan_enable_bank dma_chan_enable_bank_chk #(.NUM_CH(NUM_CH)) u_chk (
  .clk(clk), .rst(rst),
  .req_wr(req_wr), .err_wr(err_wr), .err_wdata(err_wdata),
  .err_set(err_set), .err_clr(err_clr),
  .ch_err(ch_err), .auto_clr(auto_clr),
  .req_set_mask(req_set_mask), .err_set_mask(err_set_mask),
  .err_clr_mask(err_clr_mask),
  .rd_sel(rd_sel), .rd_data(rd_data),
  .req_map(req_map), .err_map(err_map), .err_irq(err_irq)
);

// File: tb/tb_dma_chan_enable_bank.sv
module tb_dma_chan_enable_bank;
  localparam int N = 16;

  logic clk = 1'b0;
  logic rst;
  logic req_wr, req_set, req_clr, err_wr, err_set, err_clr;
  logic [N-1:0] req_wdata, err_wdata, ch_err, major_done, dreq_flag;
  logic [7:0] req_set_code, req_clr_code, err_set_code, err_clr_code;
  logic [2:0] rd_sel;
  logic [N-1:0] rd_data, req_map, err_map, err_irq;

  int n_cmp = 0;
  int n_bad = 0;
  int cycles = 0;
  logic [N-1:0] m_req = '0, m_err = '0, m_irq = '0;

  always #4 clk = ~clk;  // 125 MHz

  dma_chan_enable_bank dut (
    .clk(clk), .rst(rst),
    .req_wr(req_wr), .req_wdata(req_wdata),
    .req_set(req_set), .req_set_code(req_set_code),
    .req_clr(req_clr), .req_clr_code(req_clr_code),
    .err_wr(err_wr), .err_wdata(err_wdata),
    .err_set(err_set), .err_set_code(err_set_code),
    .err_clr(err_clr), .err_clr_code(err_clr_code),
    .ch_err(ch_err), .major_done(major_done), .dreq_flag(dreq_flag),
    .rd_sel(rd_sel), .rd_data(rd_data),
    .req_map(req_map), .err_map(err_map), .err_irq(err_irq)
  );

  // Does a code select channel ch? (bit 6 broadcast, else bits 3..0)
  function automatic bit hits(input logic [7:0] code, input int ch);
    return code[6] ? 1'b1 : (int'(code[3:0]) == ch);
  endfunction

  function automatic logic [N-1:0] model_next(
    input logic [N-1:0] cur, input logic wr, input logic [N-1:0] wd,
    input logic st, input logic [7:0] sc, input logic cl, input logic [7:0] cc,
    input logic [N-1:0] hw);
    logic [N-1:0] r;
    for (int b = 0; b < N; b++) begin
      if (hw[b])                 r[b] = 1'b0;
      else if (cl && hits(cc, b)) r[b] = 1'b0;
      else if (st && hits(sc, b)) r[b] = 1'b1;
      else if (wr)               r[b] = wd[b];
      else                       r[b] = cur[b];
    end
    return r;
  endfunction

  function automatic logic [N-1:0] model_rd(input logic [2:0] s,
    input logic [N-1:0] rq, input logic [N-1:0] er);
    if (s == 3'd0) return rq;
    if (s == 3'd1) return er;
    return '0;
  endfunction

  task automatic check(input string tag, input string what,
                       input logic [N-1:0] act, input logic [N-1:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  task automatic idle();
    req_wr = 0; req_set = 0; req_clr = 0; err_wr = 0; err_set = 0; err_clr = 0;
    req_wdata = '0; err_wdata = '0; req_set_code = '0; req_clr_code = '0;
    err_set_code = '0; err_clr_code = '0; major_done = '0; dreq_flag = '0;
    ch_err = '0; rd_sel = 3'd0;
  endtask

  // Inputs are already driven (at a negedge); advance one edge and check.
  task automatic cyc(input string tag);
    m_irq = ch_err & m_err;
    m_req = model_next(m_req, req_wr, req_wdata, req_set, req_set_code,
                       req_clr, req_clr_code, major_done & dreq_flag);
    m_err = model_next(m_err, err_wr, err_wdata, err_set, err_set_code,
                       err_clr, err_clr_code, '0);
    @(posedge clk);
    @(negedge clk);
    check(tag, "req_map", req_map, m_req);
    check(tag, "err_map", err_map, m_err);
    check(tag, "err_irq", err_irq, m_irq);
    check(tag, "rd_data", rd_data, model_rd(rd_sel, m_req, m_err));
    idle();
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 100000) begin
        n_bad++;
        $display("FAIL watchdog actual=%0d expected<=100000", cycles);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
      end
    end
  end

  initial begin
    void'($urandom(32'd2024));
    idle();
    rst = 1'b1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R1: reset state
    check("R1", "req_map", req_map, '0);
    check("R1", "err_map", err_map, '0);
    check("R1", "err_irq", err_irq, '0);
    rst = 1'b0;
    ch_err = '1;
    cyc("R1");           // error with enables 0 -> no irq
    // R2: full writes
    err_wr = 1; err_wdata = 16'hA5C3; req_wr = 1; req_wdata = 16'h0FF0; cyc("R2");
    // R3: set ch 2 with ignored bits 7,5,4 set
    err_set = 1; err_set_code = 8'hB2; cyc("R3");
    // R4: clear ch 15
    err_clr = 1; err_clr_code = 8'h0F; cyc("R4");
    // R5: broadcast clear then broadcast set
    err_clr = 1; err_clr_code = 8'h40; cyc("R5");
    req_set = 1; req_set_code = 8'h45; cyc("R5");
    // R6: write + set + clear on the same channel
    err_wr = 1; err_wdata = 16'h0008; err_set = 1; err_set_code = 8'h03;
    err_clr = 1; err_clr_code = 8'h03; cyc("R6");
    err_set = 1; err_set_code = 8'h07; err_clr = 1; err_clr_code = 8'h01; cyc("R6");
    // R7: irq follows error AND enable one edge later
    ch_err = 16'h00FF; cyc("R7");
    ch_err = 16'h0080; cyc("R7");
    // R8: completion with flag 0 keeps, with flag 1 clears
    major_done = 16'h000F; dreq_flag = 16'h0000; cyc("R8");
    major_done = 16'h0003; dreq_flag = 16'h0001; cyc("R8");
    // R9: auto-clear beats write and set on the same bit
    req_wr = 1; req_wdata = 16'hFFFF; req_set = 1; req_set_code = 8'h04;
    major_done = 16'h0010; dreq_flag = 16'h0010; cyc("R9");
    // R10: reads of every select, no side effect
    for (int s = 0; s < 8; s++) begin
      rd_sel = 3'(s); cyc("R10");
    end
    // Random mix
    for (int i = 0; i < 3000; i++) begin
      req_wr = ($urandom % 8) == 0; req_wdata = N'($urandom);
      err_wr = ($urandom % 8) == 0; err_wdata = N'($urandom);
      req_set = ($urandom % 3) == 0; req_set_code = 8'($urandom);
      req_clr = ($urandom % 3) == 0; req_clr_code = 8'($urandom);
      err_set = ($urandom % 3) == 0; err_set_code = 8'($urandom);
      err_clr = ($urandom % 3) == 0; err_clr_code = 8'($urandom);
      if (($urandom % 4) == 0) begin
        req_set_code[6] = 1'b0; req_clr_code[6] = 1'b0;
        req_clr_code[3:0] = req_set_code[3:0];
      end
      ch_err = N'($urandom);
      major_done = N'($urandom) & N'($urandom);
      dreq_flag = N'($urandom);
      rd_sel = 3'($urandom);
      cyc("R9");
    end
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule